// File: doc/BRIEF.md
# Endpoint Flush, Soft Reset and Standby Control

This block is the command-register front end of a small multi-endpoint USB-style device controller. A host reaches it over a plain parallel bus made of an address, a write strobe, a read strobe and 8-bit data. The strobes are asynchronous to the controller clock, so they are synchronized first. The block then acts once on the rising edge of each synchronized write strobe.

Two write-only command registers are decoded:

- **Flush register.** It sends one-cycle flush pulses to the transmit FIFOs of selected endpoints. A pulse goes out only when that endpoint is currently configured as a transmitter.
- **System-control register.** It issues a one-cycle soft-reset pulse, or a keyed write that parks the controller in standby. In standby the oscillator-enable output is deasserted and FIFO access is refused, while register reads and writes keep working. Only the hardware reset input ends standby.

Reads of three read-only addresses return the received byte counts of endpoints 0 to 2. The FIFOs, the USB signalling and the oscillator itself lie outside the block and appear only as ports.

Top module: `ep_ctrl_standby_regs`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `flush_pulse`, `soft_rst_pulse`, `standby`, `fifo_rd_gnt`, `fifo_wr_gnt` and `bus_rdata` are all zero, and `osc_enable` is one.
- R2: A write to address 4Eh produces one pulse on `flush_pulse[i]` for each data bit i+1 (bits 1, 2 and 3 select endpoints 1, 2 and 3) that is set, provided `ep_tx_mode[i]` is 1. Several endpoints can be flushed in one write. Data bits 0 and 4 to 7 select nothing.
- R3: A flush bit written for an endpoint whose `ep_tx_mode` bit is 0 (receive) produces no pulse for that endpoint.
- R4: Each write yields at most one pulse per output, whatever the length of the strobe, and every pulse is exactly one clock cycle wide.
- R5: A write to address 4Fh with data bit 0 set produces exactly one `soft_rst_pulse`. A soft reset never coincides with a flush pulse.
- R6: A write to address 4Fh whose upper nibble is 1010b and whose bit 0 is 0 sets `standby` and clears `osc_enable`. Any other upper nibble leaves both unchanged.
- R7: While `standby` is 1, `fifo_rd_gnt` and `fifo_wr_gnt` stay 0 whatever the requests are. Register reads and flush writes still work.
- R8: Once set, `standby` stays 1 through soft resets and any further register writes, until `rst` is asserted.
- R9: A 4Fh write with both bit 0 set and upper nibble 1010b (value A1h) gives a soft-reset pulse and does not enter standby.
- R10: Reads of C9h, CAh and CBh return the 7-bit received byte count of endpoints 0, 1 and 2, with bit 7 zero.
- R11: Reads of 4Eh, 4Fh or any undecoded address return 00h, and writes to undecoded addresses produce no pulse and no standby.
- R12: Outside standby, `fifo_rd_gnt` and `fifo_wr_gnt` follow `fifo_rd_req` and `fifo_wr_req` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Hardware reset pin, synchronous, active high; the only way out of standby |
| bus_addr | input | 8 | Host bus address, stable while a strobe is high and for a few cycles after |
| bus_wdata | input | 8 | Host bus write data |
| bus_wr | input | 1 | Host write strobe, active high, asynchronous |
| bus_rd | input | 1 | Host read strobe, active high, asynchronous |
| bus_rdata | output | 8 | Registered read data |
| ep_tx_mode | input | 3 | Bit i is 1 when endpoint i+1 is configured as a transmitter |
| rx_byte_cnt | input | 21 | Received byte counts, 7 bits per endpoint, endpoint 0 in the low bits |
| fifo_rd_req | input | 1 | FIFO read request from the data path |
| fifo_wr_req | input | 1 | FIFO write request from the data path |
| fifo_rd_gnt | output | 1 | FIFO read permitted |
| fifo_wr_gnt | output | 1 | FIFO write permitted |
| flush_pulse | output | 3 | One-cycle flush of endpoint i+1 transmit FIFO and its packet-ready flag |
| soft_rst_pulse | output | 1 | One-cycle soft reset of the controller |
| standby | output | 1 | Controller is parked in standby |
| osc_enable | output | 1 | Oscillator run enable, low in standby |

## Verification
Two pairs of functions can land in the same cycle here.

The first pair is soft reset and standby entry, both carried by one system-control write. Writing A1h forces that overlap. The bench judges it by counting exactly one soft-reset pulse and seeing the standby flag stay low.

The second pair is a flush command and a pending FIFO request that arrive while the block is in standby. The bench holds both FIFO requests high across the standby write. It then expects the grants to drop while a flush written during standby still produces its single pulse, and only a hardware reset restores the grants.

// File: rtl/ecsr_pkg.sv
package ecsr_pkg;
  localparam logic [7:0] ADR_FLUSH  = 8'h4E;
  localparam logic [7:0] ADR_SYSCTL = 8'h4F;
  localparam logic [7:0] ADR_RXCNT0 = 8'hC9;
  localparam logic [3:0] STBY_KEY   = 4'hA;
  localparam int         SOFT_BIT   = 0;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_FLUSH  = 2'd1,
    CMD_SYSCTL = 2'd2
  } cmd_e;
endpackage

// File: rtl/ecsr_strobe_sync.sv
module ecsr_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strb_in,
  output logic level,
  output logic rise
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[LEN-2:0], strb_in};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R4
endmodule

// File: rtl/ecsr_cmd_decode.sv
module ecsr_cmd_decode
  import ecsr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_TX_EP = 3,
  parameter int TX_FIRST  = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_rise,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_TX_EP-1:0] tx_mode,
  output logic [NUM_TX_EP-1:0] flush_q,
  output logic                 soft_q,
  output logic                 standby_q
);
  localparam int KEY_LSB = DATA_W - 4;

  cmd_e cmd;
  logic key_ok;

  always_comb begin
    cmd = CMD_NONE;
    if (wr_rise) begin
      if (addr == ADDR_W'(ADR_FLUSH))       cmd = CMD_FLUSH;
      else if (addr == ADDR_W'(ADR_SYSCTL)) cmd = CMD_SYSCTL;
    end
  end

  assign key_ok = (wdata[DATA_W-1:KEY_LSB] == STBY_KEY) && !wdata[SOFT_BIT];

  for (genvar i = 0; i < NUM_TX_EP; i++) begin : g_flush
    always_ff @(posedge clk) begin
      if (rst) flush_q[i] <= 1'b0;
      else     flush_q[i] <= (cmd == CMD_FLUSH) && wdata[TX_FIRST+i] && tx_mode[i];
    end

    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      flush_q[i] |=> !flush_q[i]); // R4
  end

  always_ff @(posedge clk) begin
    if (rst) soft_q <= 1'b0;
    else     soft_q <= (cmd == CMD_SYSCTL) && wdata[SOFT_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst)                              standby_q <= 1'b0;
    else if ((cmd == CMD_SYSCTL) && key_ok) standby_q <= 1'b1;
  end

  AST_SOFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    soft_q |=> !soft_q); // R5
  AST_SOFT_NOT_FLUSH: assert property (@(posedge clk) disable iff (rst)
    soft_q |-> (flush_q == '0)); // R5
  AST_STANDBY_STICKY: assert property (@(posedge clk) disable iff (rst)
    standby_q |=> standby_q); // R8
  AST_STANDBY_NO_SOFT: assert property (@(posedge clk) disable iff (rst)
    $rose(standby_q) |-> !soft_q); // R9
endmodule

// File: rtl/ecsr_rd_mux.sv
module ecsr_rd_mux
  import ecsr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_RX_EP = 3,
  parameter int CNT_W     = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_level,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_RX_EP*CNT_W-1:0] rx_cnt,
  output logic [DATA_W-1:0]          rdata_q
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [NUM_RX_EP-1:0] hit;
  logic [DATA_W-1:0]    nxt;

  for (genvar i = 0; i < NUM_RX_EP; i++) begin : g_hit
    assign hit[i] = (addr == ADDR_W'(ADR_RXCNT0) + ADDR_W'(i));
  end

  always_comb begin
    nxt = '0;
    for (int i = 0; i < NUM_RX_EP; i++) begin
      nxt = nxt | ({{PAD_W{1'b0}}, rx_cnt[i*CNT_W +: CNT_W]} & {DATA_W{hit[i]}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata_q <= '0;
    else if (rd_level) rdata_q <= nxt;
    else               rdata_q <= '0;
  end

  AST_RD_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)); // R10
endmodule

// File: rtl/ecsr_fifo_gate.sv
module ecsr_fifo_gate (
  input  logic clk,
  input  logic rst,
  input  logic standby,
  input  logic rd_req,
  input  logic wr_req,
  output logic rd_gnt,
  output logic wr_gnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_gnt <= 1'b0;
      wr_gnt <= 1'b0;
    end else begin
      rd_gnt <= rd_req && !standby;
      wr_gnt <= wr_req && !standby;
    end
  end
endmodule

// File: rtl/ep_ctrl_standby_regs.sv
module ep_ctrl_standby_regs #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int NUM_TX_EP   = 3,
  parameter int TX_FIRST    = 1,
  parameter int NUM_RX_EP   = 3,
  parameter int CNT_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_TX_EP-1:0]       ep_tx_mode,
  input  logic [NUM_RX_EP*CNT_W-1:0] rx_byte_cnt,
  input  logic                       fifo_rd_req,
  input  logic                       fifo_wr_req,
  output logic                       fifo_rd_gnt,
  output logic                       fifo_wr_gnt,
  output logic [NUM_TX_EP-1:0]       flush_pulse,
  output logic                       soft_rst_pulse,
  output logic                       standby,
  output logic                       osc_enable
);
  logic wr_level, wr_rise;
  logic rd_level, rd_rise;

  ecsr_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst(rst), .strb_in(bus_wr), .level(wr_level), .rise(wr_rise));

  ecsr_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst(rst), .strb_in(bus_rd), .level(rd_level), .rise(rd_rise));

  ecsr_cmd_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_TX_EP(NUM_TX_EP), .TX_FIRST(TX_FIRST)
  ) u_cmd (
    .clk(clk), .rst(rst), .wr_rise(wr_rise), .addr(bus_addr), .wdata(bus_wdata),
    .tx_mode(ep_tx_mode), .flush_q(flush_pulse), .soft_q(soft_rst_pulse),
    .standby_q(standby));

  ecsr_rd_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RX_EP(NUM_RX_EP), .CNT_W(CNT_W)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_level(rd_level), .addr(bus_addr),
    .rx_cnt(rx_byte_cnt), .rdata_q(bus_rdata));

  ecsr_fifo_gate u_gate (
    .clk(clk), .rst(rst), .standby(standby), .rd_req(fifo_rd_req),
    .wr_req(fifo_wr_req), .rd_gnt(fifo_rd_gnt), .wr_gnt(fifo_wr_gnt));

  assign osc_enable = ~standby;

  AST_FIFO_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    standby |=> !(fifo_rd_gnt || fifo_wr_gnt)); // R7
  AST_RD_WR_APART: assert property (@(posedge clk) disable iff (rst)
    (wr_level && rd_rise) |-> (flush_pulse == '0 || !rd_level)); // R11
  AST_OSC_STOPS: assert property (@(posedge clk) disable iff (rst)
    $rose(standby) |-> !osc_enable); // R6
endmodule

// File: tb/tb_ep_ctrl_standby_regs.sv
`timescale 1ns/1ps
module tb_ep_ctrl_standby_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [2:0]  ep_tx_mode = 3'b111;
  logic [20:0] rx_byte_cnt = {7'h55, 7'h7F, 7'h03};
  logic        fifo_rd_req = 1'b0, fifo_wr_req = 1'b0;
  logic        fifo_rd_gnt, fifo_wr_gnt;
  logic [2:0]  flush_pulse;
  logic        soft_rst_pulse, standby, osc_enable;

  int checks = 0, errors = 0;
  int fl_cnt [3];
  int soft_cnt = 0;
  int width_bad = 0;

  always #10 clk = ~clk;

  ep_ctrl_standby_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ep_tx_mode(ep_tx_mode), .rx_byte_cnt(rx_byte_cnt),
    .fifo_rd_req(fifo_rd_req), .fifo_wr_req(fifo_wr_req),
    .fifo_rd_gnt(fifo_rd_gnt), .fifo_wr_gnt(fifo_wr_gnt),
    .flush_pulse(flush_pulse), .soft_rst_pulse(soft_rst_pulse),
    .standby(standby), .osc_enable(osc_enable));

  logic [2:0] prev_fl = '0;
  logic       prev_soft = 1'b0;
  initial begin
    for (int i = 0; i < 3; i++) fl_cnt[i] = 0;
  end
  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) fl_cnt[i] += int'(flush_pulse[i]);
    soft_cnt += int'(soft_rst_pulse);
    if ((prev_fl & flush_pulse) != 0 || (prev_soft && soft_rst_pulse)) width_bad++;
    prev_fl   <= flush_pulse;
    prev_soft <= soft_rst_pulse;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hard_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d, int hold);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    repeat (hold) @(negedge clk);
    bus_wr = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    repeat (5) @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // addr, data, tx_mode, expected flush, expected soft, expected standby
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {8'h4E, 8'h02, 3'b111, 3'b001, 1'b0, 1'b0},  // R2 single endpoint
    {8'h4E, 8'h0E, 3'b111, 3'b111, 1'b0, 1'b0},  // R2 all three in one write
    {8'h4E, 8'h0E, 3'b010, 3'b010, 1'b0, 1'b0},  // R3 mixed directions
    {8'h4E, 8'h0C, 3'b000, 3'b000, 1'b0, 1'b0},  // R3 all receive
    {8'h4E, 8'hF1, 3'b111, 3'b000, 1'b0, 1'b0},  // R2 unused bits only
    {8'h4E, 8'h08, 3'b111, 3'b100, 1'b0, 1'b0},  // R2 endpoint 3
    {8'h4F, 8'h01, 3'b111, 3'b000, 1'b1, 1'b0},  // R5 soft reset
    {8'h4F, 8'hA0, 3'b111, 3'b000, 1'b0, 1'b1},  // R6 standby key
    {8'h4F, 8'hA8, 3'b111, 3'b000, 1'b0, 1'b1},  // R6 key, low bits other than 0
    {8'h4F, 8'hA1, 3'b111, 3'b000, 1'b1, 1'b0},  // R9 reset wins
    {8'h4F, 8'hB0, 3'b111, 3'b000, 1'b0, 1'b0},  // R6 wrong nibble
    {8'h4F, 8'h50, 3'b111, 3'b000, 1'b0, 1'b0},  // R6 inverted nibble
    {8'h3E, 8'h0E, 3'b111, 3'b000, 1'b0, 1'b0}   // R11 undecoded address
  };

  initial begin
    logic [7:0] rd;
    int f0 [3];
    int s0;

    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 flush", int'(flush_pulse), 0);
    check("R1 soft", int'(soft_rst_pulse), 0);
    check("R1 standby", int'(standby), 0);
    check("R1 osc", int'(osc_enable), 1);
    check("R1 grants", int'({fifo_rd_gnt, fifo_wr_gnt}), 0);
    check("R1 rdata", int'(bus_rdata), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", int'({flush_pulse, soft_rst_pulse, standby, bus_rdata}), 0);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      hard_reset();
      ep_tx_mode = VEC[v][7:5];
      for (int i = 0; i < 3; i++) f0[i] = fl_cnt[i];
      s0 = soft_cnt;
      bus_write(VEC[v][23:16], VEC[v][15:8], 1);
      for (int i = 0; i < 3; i++)
        check($sformatf("R2/R3 vec%0d flush ep%0d", v, i + 1),
              fl_cnt[i] - f0[i], int'(VEC[v][2+i]));
      check($sformatf("R5/R9 vec%0d soft", v), soft_cnt - s0, int'(VEC[v][1]));
      check($sformatf("R6/R9 vec%0d standby", v), int'(standby), int'(VEC[v][0]));
      check($sformatf("R6 vec%0d osc", v), int'(osc_enable), int'(!VEC[v][0]));
    end

    // R4 long strobes give one pulse each
    hard_reset();
    ep_tx_mode = 3'b111;
    for (int i = 0; i < 3; i++) f0[i] = fl_cnt[i];
    s0 = soft_cnt;
    bus_write(8'h4E, 8'h0E, 9);
    bus_write(8'h4F, 8'h01, 7);
    for (int i = 0; i < 3; i++) check("R4 long flush strobe", fl_cnt[i] - f0[i], 1);
    check("R4 long soft strobe", soft_cnt - s0, 1);
    check("R4 pulse width", width_bad, 0);

    // R10 / R11 reads
    bus_read(8'hC9, rd); check("R10 ep0 count", int'(rd), 8'h03);
    bus_read(8'hCA, rd); check("R10 ep1 count", int'(rd), 8'h7F);
    bus_read(8'hCB, rd); check("R10 ep2 count", int'(rd), 8'h55);
    bus_read(8'h4E, rd); check("R11 read flush reg", int'(rd), 0);
    bus_read(8'h4F, rd); check("R11 read sysctl reg", int'(rd), 0);
    bus_read(8'hC8, rd); check("R11 read below counts", int'(rd), 0);
    bus_read(8'hCC, rd); check("R11 read above counts", int'(rd), 0);

    // R12 grants follow requests
    @(negedge clk); fifo_rd_req = 1'b1; fifo_wr_req = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 grants on", int'({fifo_rd_gnt, fifo_wr_gnt}), 2'b11);
    fifo_wr_req = 1'b0;
    @(negedge clk);
    check("R12 write grant drops", int'({fifo_rd_gnt, fifo_wr_gnt}), 2'b10);
    fifo_wr_req = 1'b1;

    // R7 standby with requests pending
    bus_write(8'h4F, 8'hA0, 1);
    check("R7 standby set", int'(standby), 1);
    check("R7 grants blocked", int'({fifo_rd_gnt, fifo_wr_gnt}), 0);
    bus_read(8'hCA, rd); check("R7 read in standby", int'(rd), 8'h7F);
    for (int i = 0; i < 3; i++) f0[i] = fl_cnt[i];
    bus_write(8'h4E, 8'h04, 1);
    check("R7 flush in standby", fl_cnt[1] - f0[1], 1);
    check("R7 grants still blocked", int'({fifo_rd_gnt, fifo_wr_gnt}), 0);

    // R8 only the reset pin leaves standby
    s0 = soft_cnt;
    bus_write(8'h4F, 8'h01, 1);
    check("R8 soft pulse in standby", soft_cnt - s0, 1);
    check("R8 standby after soft reset", int'(standby), 1);
    bus_write(8'h4F, 8'h00, 1);
    bus_write(8'h4F, 8'h50, 1);
    check("R8 standby after writes", int'(standby), 1);
    check("R8 osc still off", int'(osc_enable), 0);
    hard_reset();
    check("R8 standby cleared by pin", int'(standby), 0);
    check("R8 osc restarted", int'(osc_enable), 1);
    repeat (2) @(negedge clk);
    check("R8 grants back", int'({fifo_rd_gnt, fifo_wr_gnt}), 2'b11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule